// File: doc/BRIEF.md
# Secondary-Frame Register Access Port

This block is the slave side of a synchronous serial port that carries a continuous stream of 16-bit words from a host signal processor. A clock-enable style state machine tracks each frame. In a normal (primary) frame, the word arriving on SDI goes to the data path, and the word presented on `pri_in` is shifted back out on SDO. A primary frame can be followed by one secondary frame. In a secondary frame the host reads or writes a single byte of an internal control-register file.

The host asks for a secondary frame in one of two ways:

- **Pin request.** It pulses a dedicated request pin at any time. The pin is honoured in both modes.
- **Data-word request.** It sets the least significant bit of the primary word. This only works while the port is in its default 15-bit-data mode.

A mode bit inside the register file selects 16-bit data mode. In that mode all 16 bits are payload and only the pin can request a secondary frame.

SCLK, the frame sync, SDI and the request pin are oversampled by the fast system clock through synchronizers. For that reason each SCLK phase must last at least three system clock cycles. SDO comes with a separate output enable that drives the pad's tri-state buffer.

Top module: `secframe_port`

## Requirements
- R1: After reset `sdo_en` is 0, `pri_out` is 0, every control register is 0, and the first frame is a primary frame.
- R2: A frame starts at an SCLK rising edge with `fsync` high. SDI bits are sampled MSB first on the 16 following falling edges. In a primary frame, SDO carries `pri_in` MSB first, launched on each rising edge with `sdo_en` high. `sdo_en` returns to 0 at the first rising edge after the sixteenth bit unless a new frame starts.
- R3: In 15-bit mode (register 1, bit 0 equal to 0), `pri_out` is the received word with bit 0 forced to 0. A received bit 0 of 1 makes the next frame a secondary frame.
- R4: In 16-bit mode (register 1, bit 0 equal to 1), `pri_out` is the full received word, and its bit 0 requests nothing.
- R5: A pulse on `hw_req` at any time, whether during a primary frame, between frames or during a secondary frame, is held pending. It is not lost, and it is served by the first secondary frame allowed.
- R6: A secondary frame word is laid out as follows:
  - bit 15 is the direction (1 = read, 0 = write);
  - bits 14:8 are the register address;
  - bits 7:0 are the write data.
  
  A write frame stores exactly one byte, and no register changes at any other time.
- R7: In a secondary read frame, SDO is disabled for the first 8 bit times and then drives the addressed byte MSB first. In a secondary write frame, SDO is disabled for all 16 bit times.
- R8: Address 0 and every address at or above `NUM_REGS` read as 0 and ignore writes. This makes a zero access to address 0 a no-operation. Addresses 1 to `NUM_REGS`-1 are fully writable and readable.
- R9: A secondary frame only follows a primary frame. The frame after a secondary frame is always primary, and the direction or request bits inside a secondary word request nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, sampled on SCLK rising edges |
| sdi | input | 1 | Serial data in, sampled on SCLK falling edges |
| hw_req | input | 1 | Hardware request for a secondary frame |
| pri_in | input | 1+ADDR_W+DATA_W | Word sent on SDO in the next primary frame |
| sdo | output | 1 | Serial data out, launched on SCLK rising edges |
| sdo_en | output | 1 | Output enable for the SDO pad driver |
| pri_out | output | 1+ADDR_W+DATA_W | Last received primary word after mode handling |
| pri_vld | output | 1 | One-cycle pulse when `pri_out` is updated |
| ctrl_regs | output | NUM_REGS*DATA_W | Flattened control-register contents, register i at bits i*DATA_W |

## Verification
The bench builds the port with `NUM_REGS` = 8 and the default 7-bit address and 8-bit data fields. This places both edges of the implemented range inside a short test: address 7 is the top writable register, and address 8 is the first one that must read zero and drop writes. Address 100 is also exercised, which is far outside the implemented range. With eight registers the whole file fits in one 64-bit vector, so every secondary write is checked against a full model of the file, and a stray write to any other register is caught at once.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic {
    FK_PRI = 1'b0,
    FK_SEC = 1'b1
  } frame_kind_e;

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[gb]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q[gb] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sfp_regfile.sv
module sfp_regfile #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         mode16,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0] rd_idx;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi == 0) begin : g_nop
      // location 0 is reserved as the no-operation target
      assign regs_flat[gi*DATA_W +: DATA_W] = '0;
    end else begin : g_impl
      logic              hit;
      logic [DATA_W-1:0] val_q;
      logic [DATA_W-1:0] val_d;

      always_comb begin
        hit   = wr_en && (wr_addr == ADDR_W'(gi));
        val_d = hit ? wr_data : val_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (hit) begin
          val_q <= val_d;
        end
      end

      assign regs_flat[gi*DATA_W +: DATA_W] = val_q;
    end
  end

  always_comb begin
    rd_idx  = rd_addr[IDX_W-1:0];
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS) begin
      rd_data = regs_flat[rd_idx*DATA_W +: DATA_W];
    end
  end

  assign mode16 = regs_flat[MODE_REG*DATA_W + MODE_BIT];

  // R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R8
  unimpl_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0 || int'(wr_addr) >= NUM_REGS)) |=> $stable(regs_flat));

endmodule

// File: rtl/sfp_frame_ctl.sv
module sfp_frame_ctl
  import sfp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk_s,
  input  logic                       fsync_s,
  input  logic                       sdi_s,
  input  logic                       req_s,
  input  logic                       mode16,
  input  logic [ADDR_W+DATA_W:0]     pri_in,
  input  logic [DATA_W-1:0]          rd_data,
  output logic [ADDR_W-1:0]          rd_addr,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [ADDR_W+DATA_W:0]     pri_out,
  output logic                       pri_vld
);

  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DSTART = CNT_W'(FRAME_W - DATA_W);
  localparam logic [CNT_W-1:0] AEND   = CNT_W'(FRAME_W - DATA_W - 1);

  logic               sclk_dly_q;
  logic               sclk_rise, sclk_fall;
  logic               active_q, active_d;
  frame_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [FRAME_W-2:0] in_sh_q, in_sh_d;
  logic [FRAME_W-1:0] out_sh_q, out_sh_d;
  logic               sdo_q, sdo_d;
  logic               sdo_en_q, sdo_en_d;
  logic               rw_q, rw_d;
  logic               pend_q, pend_d;
  logic               last_pri_q, last_pri_d;
  logic [FRAME_W-1:0] pri_out_q, pri_out_d;
  logic               pri_vld_q, pri_vld_d;
  logic [FRAME_W-1:0] word;

  always_comb begin
    sclk_rise = sclk_s && !sclk_dly_q;
    sclk_fall = !sclk_s && sclk_dly_q;
    cnt_inc   = cnt_q + 1'b1;
    word      = {in_sh_q, sdi_s};
    rd_addr   = {in_sh_q[ADDR_W-2:0], sdi_s};
    wr_en     = sclk_fall && active_q && (kind_q == FK_SEC) && (cnt_q == LAST) && !rw_q;
    wr_addr   = word[FRAME_W-2 -: ADDR_W];
    wr_data   = word[DATA_W-1:0];
  end

  always_comb begin
    active_d   = active_q;
    kind_d     = kind_q;
    cnt_d      = cnt_q;
    in_sh_d    = in_sh_q;
    out_sh_d   = out_sh_q;
    sdo_d      = sdo_q;
    sdo_en_d   = sdo_en_q;
    rw_d       = rw_q;
    pend_d     = pend_q;
    last_pri_d = last_pri_q;
    pri_out_d  = pri_out_q;
    pri_vld_d  = 1'b0;

    if (sclk_rise) begin
      if (fsync_s) begin
        active_d = 1'b1;
        cnt_d    = '0;
        if (pend_q && last_pri_q) begin
          kind_d   = FK_SEC;
          pend_d   = 1'b0;
          sdo_en_d = 1'b0;
        end else begin
          kind_d   = FK_PRI;
          sdo_d    = pri_in[FRAME_W-1];
          out_sh_d = {pri_in[FRAME_W-2:0], 1'b0};
          sdo_en_d = 1'b1;
        end
      end else if (active_q && cnt_q != LAST) begin
        cnt_d = cnt_inc;
        if (kind_q == FK_PRI || (rw_q && cnt_inc >= DSTART)) begin
          sdo_d    = out_sh_q[FRAME_W-1];
          out_sh_d = {out_sh_q[FRAME_W-2:0], 1'b0};
          sdo_en_d = 1'b1;
        end else begin
          sdo_en_d = 1'b0;
        end
      end else if (active_q) begin
        active_d = 1'b0;
        sdo_en_d = 1'b0;
      end
    end

    if (sclk_fall && active_q) begin
      in_sh_d = word[FRAME_W-2:0];
      if (cnt_q == '0) begin
        rw_d = sdi_s;
      end
      if (kind_q == FK_SEC && cnt_q == AEND) begin
        out_sh_d = {rd_data, {(FRAME_W-DATA_W){1'b0}}};
      end
      if (cnt_q == LAST) begin
        last_pri_d = (kind_q == FK_PRI);
        if (kind_q == FK_PRI) begin
          pri_vld_d = 1'b1;
          if (mode16) begin
            pri_out_d = word;
          end else begin
            pri_out_d = {word[FRAME_W-1:1], 1'b0};
            if (word[0]) begin
              pend_d = 1'b1;
            end
          end
        end
      end
    end

    if (req_s) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_dly_q <= 1'b0;
      active_q   <= 1'b0;
      kind_q     <= FK_PRI;
      cnt_q      <= '0;
      in_sh_q    <= '0;
      out_sh_q   <= '0;
      sdo_q      <= 1'b0;
      sdo_en_q   <= 1'b0;
      rw_q       <= 1'b0;
      pend_q     <= 1'b0;
      last_pri_q <= 1'b0;
      pri_out_q  <= '0;
      pri_vld_q  <= 1'b0;
    end else begin
      sclk_dly_q <= sclk_s;
      active_q   <= active_d;
      kind_q     <= kind_d;
      cnt_q      <= cnt_d;
      in_sh_q    <= in_sh_d;
      out_sh_q   <= out_sh_d;
      sdo_q      <= sdo_d;
      sdo_en_q   <= sdo_en_d;
      rw_q       <= rw_d;
      pend_q     <= pend_d;
      last_pri_q <= last_pri_d;
      pri_out_q  <= pri_out_d;
      pri_vld_q  <= pri_vld_d;
    end
  end

  assign sdo     = sdo_q;
  assign sdo_en  = sdo_en_q;
  assign pri_out = pri_out_q;
  assign pri_vld = pri_vld_q;

  // R2
  sdo_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en_q |-> active_q);

  // R7
  sec_sdo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en_q && kind_q == FK_SEC) |-> (rw_q && cnt_q >= DSTART));

  // R9
  sec_after_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && kind_q == FK_SEC && cnt_q != LAST) |-> last_pri_q);

  // R5
  req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_s) |=> pend_q);

  // R3
  lsb_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_vld_q |-> (mode16 || !pri_out_q[0]));

endmodule

// File: rtl/secframe_port.sv
module secframe_port #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       fsync,
  input  logic                       sdi,
  input  logic                       hw_req,
  input  logic [ADDR_W+DATA_W:0]     pri_in,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [ADDR_W+DATA_W:0]     pri_out,
  output logic                       pri_vld,
  output logic [NUM_REGS*DATA_W-1:0] ctrl_regs
);

  localparam int SYNC_STAGES = 2;
  localparam int N_PINS      = 4;

  logic [1:0]        rst_pipe_q;
  logic              rst_n_i;
  logic [N_PINS-1:0] pins_raw, pins_s;
  logic              mode16;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_i  = rst_pipe_q[1];

  assign pins_raw = {hw_req, sdi, fsync, sclk};

  sfp_sync #(
    .WIDTH  (N_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (pins_raw),
    .q     (pins_s)
  );

  sfp_frame_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_frame (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .sclk_s  (pins_s[0]),
    .fsync_s (pins_s[1]),
    .sdi_s   (pins_s[2]),
    .req_s   (pins_s[3]),
    .mode16  (mode16),
    .pri_in  (pri_in),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .pri_out (pri_out),
    .pri_vld (pri_vld)
  );

  sfp_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .MODE_REG (MODE_REG),
    .MODE_BIT (MODE_BIT)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .mode16    (mode16),
    .regs_flat (ctrl_regs)
  );

endmodule

// File: tb/test_secframe_port.sv
`timescale 1ns/1ps
module test_secframe_port;

  localparam int NREG = 8;
  localparam int H    = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, fsync, sdi, hw_req;
  logic [15:0] pri_in;
  logic        sdo, sdo_en, pri_vld;
  logic [15:0] pri_out;
  logic [NREG*8-1:0] ctrl_regs;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m [NREG];

  always #2 clk = ~clk;

  secframe_port #(
    .ADDR_W   (7),
    .DATA_W   (8),
    .NUM_REGS (NREG),
    .MODE_REG (1),
    .MODE_BIT (0)
  ) i_secframe_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .fsync     (fsync),
    .sdi       (sdi),
    .hw_req    (hw_req),
    .pri_in    (pri_in),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .pri_out   (pri_out),
    .pri_vld   (pri_vld),
    .ctrl_regs (ctrl_regs)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] model();
    logic [63:0] r = '0;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = m[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int req_bit,
                       output logic [15:0] so, output logic [15:0] en, output logic tail);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; fsync = (i == 0);
      if (i == req_bit) hw_req = 1'b1;
      wclk(H);
      hw_req = 1'b0;
      sclk = 1'b1; sdi = w[15-i];
      wclk(H);
      so[15-i] = sdo; en[15-i] = sdo_en;
    end
    sclk = 1'b0; fsync = 1'b0;
    wclk(H);
    sclk = 1'b1;
    wclk(H);
    tail = sdo_en;
    sclk = 1'b0;
    wclk(H);
  endtask

  task automatic pri(input logic [15:0] w, input logic [15:0] drv, input logic [15:0] exp_out,
                     input int req_bit, input string tag);
    logic [15:0] so, en;
    logic        tail;
    pri_in = drv;
    frame(w, req_bit, so, en, tail);
    chk({tag, " pri_out"}, 64'(pri_out), 64'(exp_out));
    chk("R2 primary sdo word", 64'(so), 64'(drv));
    chk("R2 primary sdo enable", 64'(en), 64'hFFFF);
    chk("R2 sdo released after frame", 64'(tail), 64'h0);
  endtask

  task automatic sec_wr(input logic [6:0] a, input logic [7:0] d, input int req_bit, input string tag);
    logic [15:0] so, en;
    logic        tail;
    frame({1'b0, a, d}, req_bit, so, en, tail);
    if (a != 0 && int'(a) < NREG) m[a] = d;
    chk("R7 write frame sdo disabled", 64'(en), 64'h0);
    chk("R7 sdo released after write", 64'(tail), 64'h0);
    chk({tag, " register file"}, ctrl_regs, model());
  endtask

  task automatic sec_rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    logic [15:0] so, en;
    logic        tail;
    frame({1'b1, a, 8'h00}, -1, so, en, tail);
    chk("R7 read frame sdo window", 64'(en), 64'h00FF);
    chk({tag, " read data"}, 64'(so[7:0]), 64'(exp));
    chk("R7 sdo released after read", 64'(tail), 64'h0);
  endtask

  task automatic t_reset();
    chk("R1 sdo_en after reset", 64'(sdo_en), 64'h0);
    chk("R1 pri_out after reset", 64'(pri_out), 64'h0);
    chk("R1 registers after reset", ctrl_regs, 64'h0);
  endtask

  task automatic t_primary();
    // R1 first frame is primary, R2 bit ordering both ways
    pri(16'h1234, 16'hA5C3, 16'h1234, -1, "R2 first primary");
  endtask

  task automatic t_lsb_request();
    pri(16'h4321, 16'h0F0F, 16'h4320, -1, "R3 lsb cleared");
    sec_wr(7'd5, 8'h3C, -1, "R6 write reg5");
    pri(16'h0001, 16'hFFFF, 16'h0000, -1, "R3 request word");
    sec_rd(7'd5, 8'h3C, "R7 read reg5");
  endtask

  task automatic t_nop_unimpl();
    pri(16'h0001, 16'h1111, 16'h0000, -1, "R3 request");
    sec_wr(7'd0, 8'hFF, -1, "R8 write addr0 ignored");
    pri(16'h0001, 16'h2222, 16'h0000, -1, "R3 request");
    sec_rd(7'd0, 8'h00, "R8 addr0 reads zero");
    pri(16'h0001, 16'h3333, 16'h0000, -1, "R3 request");
    sec_wr(7'd8, 8'h77, -1, "R8 write addr8 ignored");
    pri(16'h0001, 16'h4444, 16'h0000, -1, "R3 request");
    sec_rd(7'd8, 8'h00, "R8 addr8 reads zero");
    pri(16'h0001, 16'h5555, 16'h0000, -1, "R3 request");
    sec_wr(7'd100, 8'h99, -1, "R8 write addr100 ignored");
  endtask

  task automatic t_no_back_to_back();
    pri(16'h0001, 16'h6666, 16'h0000, -1, "R3 request");
    sec_wr(7'd6, 8'h01, 4, "R9 secondary lsb set");
    pri(16'h2222, 16'h7777, 16'h2222, -1, "R9 frame after secondary is primary");
    sec_wr(7'd7, 8'h5A, -1, "R5 pin request from secondary served");
    pri(16'h0001, 16'h8888, 16'h0000, -1, "R3 request");
    sec_rd(7'd7, 8'h5A, "R8 top register reads back");
  endtask

  task automatic t_mode16();
    pri(16'h0001, 16'h9999, 16'h0000, -1, "R3 request");
    sec_wr(7'd1, 8'h01, -1, "R4 enable 16-bit mode");
    pri(16'h00FF, 16'hAAAA, 16'h00FF, -1, "R4 full word");
    pri(16'h1111, 16'hBBBB, 16'h1111, -1, "R4 lsb requests nothing");
    pri(16'h3333, 16'hCCCC, 16'h3333, 9, "R5 mid-frame pin");
    sec_rd(7'd1, 8'h01, "R5 pin request served");
  endtask

  task automatic t_idle_pin();
    sclk = 1'b0;
    hw_req = 1'b1;
    wclk(H);
    hw_req = 1'b0;
    wclk(H);
    pri(16'h4444, 16'hDDDD, 16'h4444, -1, "R5 idle pin primary");
    sec_wr(7'd1, 8'h00, -1, "R5 idle pin request served");
    pri(16'h5555, 16'hEEEE, 16'h5554, -1, "R3 back in 15-bit mode");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) m[i] = 8'h00;
    rst_n = 1'b0;
    sclk = 1'b0; fsync = 1'b0; sdi = 1'b0; hw_req = 1'b0; pri_in = 16'h0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_primary();
    t_lsb_request();
    t_nop_unimpl();
    t_no_back_to_back();
    t_mode16();
    t_idle_pin();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule